// File: doc/BRIEF.md
# YCbCr 4:2:2 to RGB565 Stream Converter

This block turns planar 4:2:2 video into 16-bit RGB565 pixels. Each input beat carries one chroma pair (a blue-difference byte and a red-difference byte) and the two luma bytes that share it. Each output beat is one 32-bit word holding the two resulting pixels. A five-entry signed coefficient bank sets the conversion matrix. Software writes the bank through a small write port before a run.

The conversion works in fixed point with 13 fractional bits. First the chroma offset is removed. The chroma products are formed once per pair. The luma terms are then scaled with the black-level offset taken out. Each colour sum is rounded, clamped to 0..255 and truncated to 5, 6 or 5 bits. A run begins with a start pulse and a pixel count. The converter accepts half that count of pairs, rounded down. It raises a done flag once the last word has left. Both stream edges use valid/ready handshakes. With no backpressure the pipeline has a fixed latency.

Top module: `ycc422_rgb565`

## Requirements
- R1: Each unsigned chroma byte has 128 subtracted, giving a signed value, before it is multiplied.
- R2: Coefficient selector codes map as follows: 0 luma scale, 1 Cr-to-red, 2 Cr-to-green, 3 Cb-to-green, 4 Cb-to-blue. Each coefficient is a signed 16-bit value with 13 fractional bits.
- R3: Both luma samples of a beat use the same chroma terms. Red uses only Cr and blue uses only Cb. Green adds the Cr-to-green product and the Cb-to-green product.
- R4: The luma term is the luma coefficient times (Y − 16), computed as a signed value. A negative luma coefficient therefore flips the sign of the term.
- R5: Each colour sum gets 4096 added, is shifted right arithmetically by 13 bits, and is then clamped to 0..255.
- R6: A pixel keeps the top 5 bits of red in [15:11], the top 6 bits of green in [10:5] and the top 5 bits of blue in [4:0].
- R7: The output word carries the pixel of the first luma sample in [15:0] and the pixel of the second in [31:16].
- R8: While out_valid is high and out_ready is low, out_word holds steady and in_ready is low.
- R9: A run accepts exactly floor(pix_count/2) input beats and produces exactly that many words. After that, in_ready stays low, so an odd last pixel is dropped.
- R10: done rises in the cycle after the last word handshake and clears on the next start. A start with fewer than two pixels sets done in the following cycle.
- R11: With out_ready held high, a word appears 3 cycles after the clock edge that accepts its input beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 3 | Coefficient selector (R2 codes) |
| cfg_data | input | 16 | Signed coefficient value, 13 fractional bits |
| start | input | 1 | Begins a run when the block is idle |
| pix_count | input | CNT_W | Pixel count for the run |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_y0 | input | 8 | First luma sample |
| in_y1 | input | 8 | Second luma sample |
| in_cb | input | 8 | Blue-difference chroma |
| in_cr | input | 8 | Red-difference chroma |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts word |
| out_word | output | 32 | Two packed RGB565 pixels |
| done | output | 1 | Run complete flag |

## Verification
A table of twelve beats is streamed under standard-definition coefficients. The table covers black and white luma, both extreme luma codes, and saturated chroma corners. These beats make each channel clamp at both ends and make green depend on both chroma bytes. The same table is then run against a one-in-three backpressure pattern, which separates correct output holding from words that are dropped or duplicated. Single-coefficient matrices isolate the chroma offset and a negative luma scale. Odd and sub-two pixel counts exercise the count rounding and the done flag.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
  localparam int PIX_W     = 8;
  localparam int COEF_W    = 16;
  localparam int FRAC_BITS = 13;
  localparam int ACC_W     = COEF_W + PIX_W + 3;
  localparam int R_W       = 5;
  localparam int G_W       = 6;
  localparam int B_W       = 5;
  localparam int PX_W      = R_W + G_W + B_W;

  typedef enum logic [2:0] {
    CI_LUMA = 3'd0,
    CI_CR_R = 3'd1,
    CI_CR_G = 3'd2,
    CI_CB_G = 3'd3,
    CI_CB_B = 3'd4
  } coef_idx_e;

  typedef struct packed {
    logic signed [COEF_W-1:0] luma;
    logic signed [COEF_W-1:0] cr_r;
    logic signed [COEF_W-1:0] cr_g;
    logic signed [COEF_W-1:0] cb_g;
    logic signed [COEF_W-1:0] cb_b;
  } coef_set_t;
endpackage

// File: rtl/ycc_coef_bank.sv
module ycc_coef_bank
  import ycc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [COEF_W-1:0] data,
  output coef_set_t         coefs
);
  always_ff @(posedge clk) begin
    if (rst) begin
      coefs <= '0;
    end else if (we) begin
      case (coef_idx_e'(sel))
        CI_LUMA: coefs.luma <= data;
        CI_CR_R: coefs.cr_r <= data;
        CI_CR_G: coefs.cr_g <= data;
        CI_CB_G: coefs.cb_g <= data;
        CI_CB_B: coefs.cb_b <= data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ycc_term_stage.sv
module ycc_term_stage
  import ycc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       adv,
  input  coef_set_t                  k,
  input  logic [1:0][PIX_W-1:0]      y,
  input  logic [PIX_W-1:0]           cb,
  input  logic [PIX_W-1:0]           cr,
  output logic [1:0][ACC_W-1:0]      lum_t,
  output logic [ACC_W-1:0]           red_t,
  output logic [ACC_W-1:0]           grn_t,
  output logic [ACC_W-1:0]           blu_t
);
  localparam int PW1   = PIX_W + 1;
  localparam int MID   = 1 << (PIX_W - 1);
  localparam int BLACK = 16 << (PIX_W - 8);

  function automatic logic signed [ACC_W-1:0] mulx(
    input logic signed [COEF_W-1:0] a,
    input logic signed [PW1-1:0]    b
  );
    return ACC_W'(a) * ACC_W'(b);
  endfunction

  logic signed [PW1-1:0] cb_c, cr_c;
  assign cb_c = $signed({1'b0, cb}) - PW1'(MID);
  assign cr_c = $signed({1'b0, cr}) - PW1'(MID);

  for (genvar l = 0; l < 2; l++) begin : g_luma
    logic signed [PW1-1:0] yd;
    logic        [ACC_W-1:0] lt_q;
    assign yd = $signed({1'b0, y[l]}) - PW1'(BLACK);
    always_ff @(posedge clk) begin
      if (rst)      lt_q <= '0;
      else if (adv) lt_q <= mulx(k.luma, yd);
    end
    assign lum_t[l] = lt_q;
  end

  // chroma products formed once per pair and shared by both luma samples
  always_ff @(posedge clk) begin
    if (rst) begin
      red_t <= '0;
      grn_t <= '0;
      blu_t <= '0;
    end else if (adv) begin
      red_t <= mulx(k.cr_r, cr_c);
      grn_t <= mulx(k.cr_g, cr_c) + mulx(k.cb_g, cb_c);
      blu_t <= mulx(k.cb_b, cb_c);
    end
  end
endmodule

// File: rtl/ycc_clamp.sv
module ycc_clamp
  import ycc_pkg::*;
#(
  parameter int OUT_W = 5
) (
  input  logic signed [ACC_W-1:0] acc,
  output logic [OUT_W-1:0]        q
);
  localparam int HALF = 1 << (FRAC_BITS - 1);
  localparam int TOP  = (1 << PIX_W) - 1;

  logic signed [ACC_W-1:0] rnd, sh, sat;

  always_comb begin
    rnd = acc + ACC_W'(HALF);
    sh  = rnd >>> FRAC_BITS;
    if (sh < 0)                 sat = '0;
    else if (sh > ACC_W'(TOP))  sat = ACC_W'(TOP);
    else                        sat = sh;
    q = OUT_W'(sat >> (PIX_W - OUT_W));
  end
endmodule

// File: rtl/ycc_sum_stage.sv
module ycc_sum_stage
  import ycc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  adv,
  input  logic [1:0][ACC_W-1:0] lum_t,
  input  logic [ACC_W-1:0]      red_t,
  input  logic [ACC_W-1:0]      grn_t,
  input  logic [ACC_W-1:0]      blu_t,
  output logic [1:0][PX_W-1:0]  pix
);
  for (genvar p = 0; p < 2; p++) begin : g_pix
    logic signed [ACC_W-1:0] rs, gs, bs;
    logic [R_W-1:0] rq;
    logic [G_W-1:0] gq;
    logic [B_W-1:0] bq;
    logic [PX_W-1:0] px_q;

    assign rs = $signed(lum_t[p]) + $signed(red_t);
    assign gs = $signed(lum_t[p]) + $signed(grn_t);
    assign bs = $signed(lum_t[p]) + $signed(blu_t);

    ycc_clamp #(.OUT_W(R_W)) u_r (.acc(rs), .q(rq));
    ycc_clamp #(.OUT_W(G_W)) u_g (.acc(gs), .q(gq));
    ycc_clamp #(.OUT_W(B_W)) u_b (.acc(bs), .q(bq));

    always_ff @(posedge clk) begin
      if (rst)      px_q <= '0;
      else if (adv) px_q <= {rq, gq, bq};
    end
    assign pix[p] = px_q;
  end
endmodule

// File: rtl/ycc422_rgb565.sv
module ycc422_rgb565
  import ycc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_sel,
  input  logic [COEF_W-1:0]   cfg_data,
  input  logic                start,
  input  logic [CNT_W-1:0]    pix_count,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [PIX_W-1:0]    in_y0,
  input  logic [PIX_W-1:0]    in_y1,
  input  logic [PIX_W-1:0]    in_cb,
  input  logic [PIX_W-1:0]    in_cr,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2*PX_W-1:0]   out_word,
  output logic                done
);
  coef_set_t             coefs;
  logic                  adv, in_fire, out_fire, busy;
  logic                  v1, v2;
  logic [CNT_W-1:0]      in_left, out_left, pairs;
  logic [1:0][ACC_W-1:0] lum_t;
  logic [ACC_W-1:0]      red_t, grn_t, blu_t;
  logic [1:0][PX_W-1:0]  pix;

  assign adv      = !out_valid || out_ready;
  assign in_ready = (in_left != '0) && adv;
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;
  assign busy     = (out_left != '0);
  assign pairs    = pix_count >> 1;

  ycc_coef_bank u_coef (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .data(cfg_data),
    .coefs(coefs)
  );

  ycc_term_stage u_term (
    .clk(clk), .rst(rst), .adv(adv), .k(coefs),
    .y({in_y1, in_y0}), .cb(in_cb), .cr(in_cr),
    .lum_t(lum_t), .red_t(red_t), .grn_t(grn_t), .blu_t(blu_t)
  );

  ycc_sum_stage u_sum (
    .clk(clk), .rst(rst), .adv(adv),
    .lum_t(lum_t), .red_t(red_t), .grn_t(grn_t), .blu_t(blu_t),
    .pix(pix)
  );

  // stage valids and packing register
  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (adv) begin
      v1        <= in_fire;
      v2        <= v1;
      out_valid <= v2;
      out_word  <= {pix[1], pix[0]};
    end
  end

  // run control
  always_ff @(posedge clk) begin
    if (rst) begin
      in_left  <= '0;
      out_left <= '0;
      done     <= 1'b0;
    end else if (start && !busy) begin
      in_left  <= pairs;
      out_left <= pairs;
      done     <= (pairs == '0);
    end else begin
      if (in_fire)  in_left <= in_left - 1'b1;
      if (out_fire) begin
        out_left <= out_left - 1'b1;
        if (out_left == CNT_W'(1)) done <= 1'b1;
      end
    end
  end

  p_hold_stall_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  p_no_take_stall_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_in_le_out_r9: assert property (@(posedge clk) disable iff (rst)
    in_left <= out_left);

  p_no_extra_word_r9: assert property (@(posedge clk) disable iff (rst)
    out_fire |-> out_left != '0);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid);

  p_done_cause_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(start) || $past(out_fire));
endmodule

// File: tb/ycc422_rgb565_tb.sv
module ycc422_rgb565_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [15:0] cfg_data = '0;
  logic start = 1'b0;
  logic [15:0] pix_count = '0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_y0 = '0, in_y1 = '0, in_cb = '0, in_cr = '0;
  logic out_valid, out_ready = 1'b1;
  logic [31:0] out_word;
  logic done;

  int checks = 0, fails = 0;
  int lc = 0, rc = 0, grc = 0, gbc = 0, bc = 0;
  logic [31:0] stim [16];

  // {y0, y1, cb, cr}
  localparam logic [31:0] VEC [12] = '{
    {8'd16,  8'd235, 8'd128, 8'd128},
    {8'd0,   8'd255, 8'd128, 8'd128},
    {8'd81,  8'd82,  8'd90,  8'd240},
    {8'd145, 8'd144, 8'd54,  8'd34},
    {8'd41,  8'd40,  8'd240, 8'd110},
    {8'd210, 8'd211, 8'd16,  8'd146},
    {8'd170, 8'd169, 8'd166, 8'd16},
    {8'd106, 8'd107, 8'd202, 8'd222},
    {8'd0,   8'd0,   8'd255, 8'd255},
    {8'd255, 8'd255, 8'd0,   8'd0},
    {8'd128, 8'd60,  8'd128, 8'd0},
    {8'd100, 8'd200, 8'd255, 8'd128}
  };

  ycc422_rgb565 u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .start(start), .pix_count(pix_count), .in_valid(in_valid), .in_ready(in_ready),
    .in_y0(in_y0), .in_y1(in_y1), .in_cb(in_cb), .in_cr(in_cr),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .done(done)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int clampv(input int s);
    int v;
    v = (s + 4096) >>> 13;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  // R1 R3 R4 R5 R6 reference
  function automatic logic [15:0] pix_model(input int y, input int cb, input int cr);
    int yt, c, b, r, g, bl;
    logic [7:0] r8, g8, b8;
    yt = lc * (y - 16);
    c  = cr - 128;
    b  = cb - 128;
    r  = clampv(yt + rc * c);
    g  = clampv(yt + grc * c + gbc * b);
    bl = clampv(yt + bc * b);
    r8 = 8'(r); g8 = 8'(g); b8 = 8'(bl);
    return {r8[7:3], g8[7:2], b8[7:3]};
  endfunction

  task automatic load(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_data = 16'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_coefs(input int a, input int b, input int c, input int d, input int e);
    lc = a; rc = b; grc = c; gbc = d; bc = e;
    load(0, a); load(1, b); load(2, c); load(3, d); load(4, e);
  endtask

  task automatic run(input int count, input int navail, input int rmode, input bit lat_chk);
    int pairs, iidx, oidx, cyc, t_in, t_out;
    bit prev_hold;
    logic [31:0] prev_word, expw;
    pairs = count / 2; iidx = 0; oidx = 0; cyc = 0; t_in = -1; t_out = -1;
    prev_hold = 1'b0; prev_word = '0;
    @(negedge clk);
    start = 1'b1; pix_count = 16'(count);
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R10", "done cleared by start", 32'(done), 32'd0);
    while (oidx < pairs && cyc < 2000) begin
      in_valid = (iidx < navail);
      {in_y0, in_y1, in_cb, in_cr} = stim[iidx < 16 ? iidx : 0];
      out_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
      #1;
      if (prev_hold)
        chk(out_valid && out_word == prev_word, "R8", "word held under stall", out_word, prev_word);
      if (out_valid && t_out < 0) t_out = cyc;
      if (in_valid && in_ready) begin
        if (t_in < 0) t_in = cyc;
        iidx++;
      end
      if (out_valid && out_ready) begin
        expw = {pix_model(stim[oidx][23:16], stim[oidx][15:8], stim[oidx][7:0]),
                pix_model(stim[oidx][31:24], stim[oidx][15:8], stim[oidx][7:0])};
        chk(out_word == expw, "R7", "packed pixel pair (R3 R5 R6)", out_word, expw);
        oidx++;
      end
      prev_hold = out_valid && !out_ready;
      prev_word = out_word;
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0; out_ready = 1'b1;
    #1;
    chk(done == 1'b1, "R10", "done after last word", 32'(done), 32'd1);
    chk(iidx == pairs, "R9", "beats accepted", 32'(iidx), 32'(pairs));
    in_valid = (navail > pairs);
    #1;
    chk(in_ready == 1'b0, "R9", "in_ready low after run", 32'(in_ready), 32'd0);
    if (lat_chk)
      chk(t_out - t_in == 3, "R11", "latency cycles", 32'(t_out - t_in), 32'd3);
    repeat (5) begin
      @(negedge clk); #1;
      chk(out_valid == 1'b0, "R9", "no extra word", 32'(out_valid), 32'd0);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R10", "reset out_valid", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b0, "R9", "reset in_ready", 32'(in_ready), 32'd0);
    chk(done == 1'b0, "R10", "reset done", 32'(done), 32'd0);

    // R2: standard-definition matrix, Q13 coefficients
    set_coefs(9535, 13074, -6660, -3203, 16531);
    for (int i = 0; i < 12; i++) stim[i] = VEC[i];
    run(24, 12, 0, 1'b1);
    // R8: same table under backpressure
    run(24, 12, 1, 1'b0);
    // R9: odd count, extra beat offered
    run(5, 4, 0, 1'b0);

    // R1: red from Cr only, chroma offset 128
    set_coefs(0, 8192, 0, 0, 0);
    stim[0] = {8'd50, 8'd60, 8'd128, 8'd228};
    stim[1] = {8'd50, 8'd60, 8'd128, 8'd28};
    run(4, 2, 0, 1'b0);
    chk(pix_model(0, 128, 228) == 16'h6000, "R1", "model sanity red 100", 32'(pix_model(0, 128, 228)), 32'h6000);

    // R4: negative luma scale, green mixes both chroma terms (R3)
    set_coefs(-8192, 0, 4096, 4096, 0);
    stim[0] = {8'd0, 8'd10, 8'd128, 8'd128};
    stim[1] = {8'd255, 8'd12, 8'd200, 8'd160};
    run(4, 2, 0, 1'b0);

    // R10: fewer than two pixels
    @(negedge clk);
    start = 1'b1; pix_count = 16'd1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(done == 1'b1, "R10", "done for empty run", 32'(done), 32'd1);
    chk(in_ready == 1'b0, "R9", "no beats for empty run", 32'(in_ready), 32'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule